// File: doc/BRIEF.md
# Camera Receiver Control Register Bank

This block is the software-visible control and status register bank of a serial camera receiver. A host reaches it over a plain 32-bit register bus: one select, one write flag, a byte address and a write word. Reads return their data one clock after the request. The bank holds settings for the receiver datapath. These cover the number of lanes, the data type code, the high-speed settle count, the output word alignment and the frame size. Writes to these settings only change staging copies. The datapath sees them after software sets a self-clearing commit bit, which moves every staged setting into the active copies in one clock.

Receiver enable, lane pair polarity swap, wrapper clock select and the per-lane PHY enables act at once and are not staged. Event pulses from the datapath set sticky pending bits, and software clears them by writing ones. A registered interrupt line reports any pending bit whose mask bit is set. A self-clearing software reset bit sends the datapath a reset pulse of fixed length. The same reset clears all pending bits and leaves the staged settings as they are.

Top module: `camrx_regbank`

## Requirements
- R1: After reset every register reads 0. irq_o, dp_rst_o, bus_rdata and all configuration outputs are 0.
- R2: Register offsets and fields are as follows. At 0x00, control: bit 31 pair swap, bit 20 align32, bit 16 commit, bit 8 wrapper clock select, bit 4 software reset, bit 0 enable. At 0x04, PHY: bits 31:27 settle count, bits 4:0 lane enables. At 0x08, config: bits 7:2 data type code, bits 1:0 lanes minus one. At 0x10, mask. At 0x14, pending. At 0x2C, size: bits 31:16 width, bits 15:0 height. A read returns the staged value on bus_rdata one cycle after the request. Unimplemented bits read 0.
- R3: Enable, pair swap, wrapper clock select and lane enables reach their outputs on the clock edge that takes the write.
- R4: Writes to align32, settle count, lane count, data type code, width or height do not change the act_* outputs until a commit.
- R5: A control write with bit 16 set loads all staged settings, including those in the same write, into the act_* outputs on that edge. Bit 16 always reads back 0.
- R6: A control write with bit 4 set drives dp_rst_o high for RST_LEN cycles (16 by default), starting the cycle after the write. It clears the pending register and keeps the staged settings. Bit 4 always reads back 0.
- R7: An event pulse on evt_in sets the matching pending bit, which stays set. Only the bits in 0xF000003F exist.
- R8: Writing 1 to a pending bit clears it. Writing 0 leaves it unchanged.
- R9: An event and a clearing write to the same pending bit in the same cycle leave the bit set.
- R10: irq_o is a register holding the OR of (pending AND mask). It follows the pending and mask state one cycle later.
- R11: Reads of unmapped offsets return 0. Writes to them change no register.
- R12: Only the mask bits in 0xF000003F can be set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a read |
| evt_in | input | 32 | Event pulses, one per pending bit |
| irq_o | output | 1 | Masked interrupt |
| dp_rst_o | output | 1 | Datapath reset pulse |
| rx_enable_o | output | 1 | Receiver enable |
| pair_swap_o | output | 1 | Data pair polarity swap |
| ext_wclk_o | output | 1 | Wrapper clock select |
| lane_en_o | output | 5 | Per-lane PHY enables |
| act_lanes_o | output | 2 | Active lane count minus one |
| act_dtype_o | output | 6 | Active data type code |
| act_settle_o | output | 5 | Active settle count |
| act_align32_o | output | 1 | Active 32-bit alignment |
| act_width_o | output | 16 | Active frame width |
| act_height_o | output | 16 | Active frame height |

## Verification
Write effects on direct and active outputs appear on the edge that takes the write, so they are sampled on the falling edge right after it. Read data appears one cycle after the request, and the monitor compares it on the falling edge after that clock. A pending bit changes one edge after its event or write, and irq_o changes one edge after that. The bench therefore samples irq_o on both falling edges to tell the old value from the new one. The reset pulse is counted on each falling edge for RST_LEN edges high and then checked low on the next one.

// File: rtl/camrx_pkg.sv
package camrx_pkg;
  localparam logic [7:0] OFS_CTRL = 8'h00;
  localparam logic [7:0] OFS_PHY  = 8'h04;
  localparam logic [7:0] OFS_CFG  = 8'h08;
  localparam logic [7:0] OFS_MASK = 8'h10;
  localparam logic [7:0] OFS_SRC  = 8'h14;
  localparam logic [7:0] OFS_SIZE = 8'h2C;

  localparam int B_SWAP   = 31;
  localparam int B_ALIGN  = 20;
  localparam int B_COMMIT = 16;
  localparam int B_WCLK   = 8;
  localparam int B_SWRST  = 4;
  localparam int B_EN     = 0;

  localparam int SETTLE_W = 5;
  localparam int LANEEN_W = 5;
  localparam int DTYPE_W  = 6;
  localparam int LANES_W  = 2;
  localparam int DIM_W    = 16;

  typedef struct packed {
    logic                align32;
    logic [SETTLE_W-1:0] settle;
    logic [LANES_W-1:0]  lanes;
    logic [DTYPE_W-1:0]  dtype;
    logic [DIM_W-1:0]    width;
    logic [DIM_W-1:0]    height;
  } stage_cfg_t;

  typedef struct packed {
    logic                swap;
    logic                wclk;
    logic                enable;
    logic [LANEEN_W-1:0] lane_en;
  } direct_ctl_t;
endpackage

// File: rtl/camrx_rst_sync.sv
module camrx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_ns = stage_q[1];
endmodule

// File: rtl/camrx_bus_decode.sv
module camrx_bus_decode
  import camrx_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_ns,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  stage_cfg_t        stg,
  input  direct_ctl_t       dir,
  input  logic [31:0]       mask_q,
  input  logic [31:0]       src_q,
  output logic              we_ctrl,
  output logic              we_phy,
  output logic              we_cfg,
  output logic              we_mask,
  output logic              we_src,
  output logic              we_size,
  output logic [31:0]       rdata
);
  logic [7:0]  a8;
  logic        hit_ctrl, hit_phy, hit_cfg, hit_mask, hit_src, hit_size, mapped;
  logic        rd_en;
  logic [31:0] rd_mux;
  logic [31:0] rdata_d;

  assign a8       = 8'(bus_addr);
  assign hit_ctrl = (a8[7:2] == OFS_CTRL[7:2]);
  assign hit_phy  = (a8[7:2] == OFS_PHY[7:2]);
  assign hit_cfg  = (a8[7:2] == OFS_CFG[7:2]);
  assign hit_mask = (a8[7:2] == OFS_MASK[7:2]);
  assign hit_src  = (a8[7:2] == OFS_SRC[7:2]);
  assign hit_size = (a8[7:2] == OFS_SIZE[7:2]);
  assign mapped   = hit_ctrl | hit_phy | hit_cfg | hit_mask | hit_src | hit_size;

  assign we_ctrl = bus_sel & bus_wr & hit_ctrl;
  assign we_phy  = bus_sel & bus_wr & hit_phy;
  assign we_cfg  = bus_sel & bus_wr & hit_cfg;
  assign we_mask = bus_sel & bus_wr & hit_mask;
  assign we_src  = bus_sel & bus_wr & hit_src;
  assign we_size = bus_sel & bus_wr & hit_size;
  assign rd_en   = bus_sel & ~bus_wr;

  // read mux; self-clearing bits are never stored so read as 0
  always_comb begin
    rd_mux = '0;
    if (hit_ctrl) begin
      rd_mux[B_SWAP]  = dir.swap;
      rd_mux[B_ALIGN] = stg.align32;
      rd_mux[B_WCLK]  = dir.wclk;
      rd_mux[B_EN]    = dir.enable;
    end else if (hit_phy) begin
      rd_mux[31:32-SETTLE_W] = stg.settle;
      rd_mux[LANEEN_W-1:0]   = dir.lane_en;
    end else if (hit_cfg) begin
      rd_mux[DTYPE_W+LANES_W-1:LANES_W] = stg.dtype;
      rd_mux[LANES_W-1:0]               = stg.lanes;
    end else if (hit_mask) begin
      rd_mux = mask_q;
    end else if (hit_src) begin
      rd_mux = src_q;
    end else if (hit_size) begin
      rd_mux = {stg.width, stg.height};
    end
  end

  always_comb begin
    rdata_d = rdata;
    if (rd_en) rdata_d = rd_mux;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) rdata <= '0;
    else         rdata <= rdata_d;
  end

  // R11: reading an unmapped offset yields zero data next cycle
  a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_ns)
    (rd_en && !mapped) |=> (rdata == 32'h0));
endmodule

// File: rtl/camrx_cfg_shadow.sv
module camrx_cfg_shadow
  import camrx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_ns,
  input  logic        we_ctrl,
  input  logic        we_phy,
  input  logic        we_cfg,
  input  logic        we_size,
  input  logic [31:0] wdata,
  output stage_cfg_t  stg_q,
  output direct_ctl_t dir_q,
  output stage_cfg_t  act_q
);
  stage_cfg_t  stg_d, act_d;
  direct_ctl_t dir_d;
  logic        commit;

  assign commit = we_ctrl & wdata[B_COMMIT];

  always_comb begin
    stg_d = stg_q;
    dir_d = dir_q;
    if (we_ctrl) begin
      stg_d.align32 = wdata[B_ALIGN];
      dir_d.swap    = wdata[B_SWAP];
      dir_d.wclk    = wdata[B_WCLK];
      dir_d.enable  = wdata[B_EN];
    end
    if (we_phy) begin
      stg_d.settle  = wdata[31:32-SETTLE_W];
      dir_d.lane_en = wdata[LANEEN_W-1:0];
    end
    if (we_cfg) begin
      stg_d.dtype = wdata[DTYPE_W+LANES_W-1:LANES_W];
      stg_d.lanes = wdata[LANES_W-1:0];
    end
    if (we_size) begin
      stg_d.width  = wdata[31:16];
      stg_d.height = wdata[15:0];
    end
  end

  // commit takes the staging values including the same write
  always_comb begin
    act_d = act_q;
    if (commit) act_d = stg_d;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      stg_q <= '0;
      dir_q <= '0;
      act_q <= '0;
    end else begin
      stg_q <= stg_d;
      dir_q <= dir_d;
      act_q <= act_d;
    end
  end

  // R4: active copy only moves on a commit
  a_r4_active_hold: assert property (@(posedge clk) disable iff (!rst_ns)
    !commit |=> $stable(act_q));
  // R5: after a commit active equals staging
  a_r5_commit_match: assert property (@(posedge clk) disable iff (!rst_ns)
    commit |=> (act_q == stg_q));
endmodule

// File: rtl/camrx_irq_ctl.sv
module camrx_irq_ctl #(
  parameter logic [31:0] IMPL = 32'hF000_003F
) (
  input  logic        clk,
  input  logic        rst_ns,
  input  logic        we_mask,
  input  logic        we_src,
  input  logic        sw_rst,
  input  logic [31:0] wdata,
  input  logic [31:0] evt_in,
  output logic [31:0] mask_q,
  output logic [31:0] src_q,
  output logic        irq_o
);
  logic [31:0] clr_vec;
  logic [31:0] src_d, mask_d;
  logic        irq_d;

  always_comb begin
    clr_vec = '0;
    if (we_src) clr_vec = wdata;
    if (sw_rst) clr_vec = '1;
  end

  for (genvar i = 0; i < 32; i++) begin : g_bit
    if (IMPL[i]) begin : g_impl
      // event has priority over a clear in the same cycle
      assign src_d[i]  = evt_in[i] | (src_q[i] & ~clr_vec[i]);
      assign mask_d[i] = we_mask ? wdata[i] : mask_q[i];
    end else begin : g_none
      assign src_d[i]  = 1'b0;
      assign mask_d[i] = 1'b0;
    end
  end

  assign irq_d = |(src_q & mask_q);

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      src_q  <= '0;
      mask_q <= '0;
      irq_o  <= 1'b0;
    end else begin
      src_q  <= src_d;
      mask_q <= mask_d;
      irq_o  <= irq_d;
    end
  end

  // R7: pending bits stay put without events, clears or reset
  a_r7_sticky: assert property (@(posedge clk) disable iff (!rst_ns)
    (evt_in == 32'h0 && !we_src && !sw_rst) |=> $stable(src_q));
  // R9: an event leaves its bit set whatever write accompanies it
  a_r9_event_wins: assert property (@(posedge clk) disable iff (!rst_ns)
    ((evt_in & IMPL) != 32'h0) |=> ((src_q & $past(evt_in & IMPL)) == $past(evt_in & IMPL)));
  // R10: no enabled pending bit means no interrupt next cycle
  a_r10_irq_quiet: assert property (@(posedge clk) disable iff (!rst_ns)
    ((src_q & mask_q) == 32'h0) |=> !irq_o);
  // R12: mask never holds unimplemented bits
  a_r12_mask_impl: assert property (@(posedge clk) disable iff (!rst_ns)
    we_mask |=> ((mask_q & ~IMPL) == 32'h0));
endmodule

// File: rtl/camrx_rst_pulse.sv
module camrx_rst_pulse #(
  parameter int RST_LEN = 16
) (
  input  logic clk,
  input  logic rst_ns,
  input  logic sw_rst,
  output logic dp_rst_o
);
  localparam int CW = $clog2(RST_LEN + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (sw_rst)              cnt_d = CW'(RST_LEN);
    else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign dp_rst_o = (cnt_q != '0);

  // R6: request starts the pulse on the next cycle
  a_r6_pulse_start: assert property (@(posedge clk) disable iff (!rst_ns)
    sw_rst |=> dp_rst_o);
  // R6: no pulse appears without a request
  a_r6_no_spurious: assert property (@(posedge clk) disable iff (!rst_ns)
    (!sw_rst && !dp_rst_o) |=> !dp_rst_o);
endmodule

// File: rtl/camrx_regbank.sv
module camrx_regbank
  import camrx_pkg::*;
#(
  parameter int          ADDR_W  = 6,
  parameter int          RST_LEN = 16,
  parameter logic [31:0] IRQ_IMPL = 32'hF000_003F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [31:0]       evt_in,
  output logic              irq_o,
  output logic              dp_rst_o,
  output logic              rx_enable_o,
  output logic              pair_swap_o,
  output logic              ext_wclk_o,
  output logic [4:0]        lane_en_o,
  output logic [1:0]        act_lanes_o,
  output logic [5:0]        act_dtype_o,
  output logic [4:0]        act_settle_o,
  output logic              act_align32_o,
  output logic [15:0]       act_width_o,
  output logic [15:0]       act_height_o
);
  logic        rst_ns;
  logic        we_ctrl, we_phy, we_cfg, we_mask, we_src, we_size;
  logic        sw_rst;
  stage_cfg_t  stg_q, act_q;
  direct_ctl_t dir_q;
  logic [31:0] mask_q, src_q;

  camrx_rst_sync u_rsync (
    .clk   (clk),
    .rst_n (rst_n),
    .rst_ns(rst_ns)
  );

  camrx_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
    .clk     (clk),
    .rst_ns  (rst_ns),
    .bus_sel (bus_sel),
    .bus_wr  (bus_wr),
    .bus_addr(bus_addr),
    .stg     (stg_q),
    .dir     (dir_q),
    .mask_q  (mask_q),
    .src_q   (src_q),
    .we_ctrl (we_ctrl),
    .we_phy  (we_phy),
    .we_cfg  (we_cfg),
    .we_mask (we_mask),
    .we_src  (we_src),
    .we_size (we_size),
    .rdata   (bus_rdata)
  );

  assign sw_rst = we_ctrl & bus_wdata[B_SWRST];

  camrx_cfg_shadow u_shd (
    .clk    (clk),
    .rst_ns (rst_ns),
    .we_ctrl(we_ctrl),
    .we_phy (we_phy),
    .we_cfg (we_cfg),
    .we_size(we_size),
    .wdata  (bus_wdata),
    .stg_q  (stg_q),
    .dir_q  (dir_q),
    .act_q  (act_q)
  );

  camrx_irq_ctl #(.IMPL(IRQ_IMPL)) u_irq (
    .clk    (clk),
    .rst_ns (rst_ns),
    .we_mask(we_mask),
    .we_src (we_src),
    .sw_rst (sw_rst),
    .wdata  (bus_wdata),
    .evt_in (evt_in),
    .mask_q (mask_q),
    .src_q  (src_q),
    .irq_o  (irq_o)
  );

  camrx_rst_pulse #(.RST_LEN(RST_LEN)) u_rpl (
    .clk     (clk),
    .rst_ns  (rst_ns),
    .sw_rst  (sw_rst),
    .dp_rst_o(dp_rst_o)
  );

  assign rx_enable_o   = dir_q.enable;
  assign pair_swap_o   = dir_q.swap;
  assign ext_wclk_o    = dir_q.wclk;
  assign lane_en_o     = dir_q.lane_en;
  assign act_lanes_o   = act_q.lanes;
  assign act_dtype_o   = act_q.dtype;
  assign act_settle_o  = act_q.settle;
  assign act_align32_o = act_q.align32;
  assign act_width_o   = act_q.width;
  assign act_height_o  = act_q.height;

  // R3: direct controls follow a control write on the same edge
  a_r3_direct_ctl: assert property (@(posedge clk) disable iff (!rst_ns)
    we_ctrl |=> (rx_enable_o == $past(bus_wdata[B_EN]) && pair_swap_o == $past(bus_wdata[B_SWAP])));
  // R6: the staged settings survive a software reset request
  a_r6_keep_stage: assert property (@(posedge clk) disable iff (!rst_ns)
    (sw_rst && !we_phy && !we_cfg && !we_size) |=> (stg_q.dtype == $past(stg_q.dtype)));
endmodule

// File: tb/sim_camrx_regbank.sv
module sim_camrx_regbank;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [5:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata, evt_in;
  logic        irq_o, dp_rst_o, rx_enable_o, pair_swap_o, ext_wclk_o, act_align32_o;
  logic [4:0]  lane_en_o, act_settle_o;
  logic [1:0]  act_lanes_o;
  logic [5:0]  act_dtype_o;
  logic [15:0] act_width_o, act_height_o;

  int total = 0;
  int bad   = 0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } rd_item_t;
  rd_item_t exp_q[$];
  logic     rd_seen;

  always #4 clk = ~clk;

  camrx_regbank u0 (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_in(evt_in), .irq_o(irq_o), .dp_rst_o(dp_rst_o),
    .rx_enable_o(rx_enable_o), .pair_swap_o(pair_swap_o), .ext_wclk_o(ext_wclk_o),
    .lane_en_o(lane_en_o), .act_lanes_o(act_lanes_o), .act_dtype_o(act_dtype_o),
    .act_settle_o(act_settle_o), .act_align32_o(act_align32_o),
    .act_width_o(act_width_o), .act_height_o(act_height_o)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: compares read data the cycle after each read request
  always @(posedge clk) rd_seen <= bus_sel & ~bus_wr & rst_n;
  always @(negedge clk) begin
    if (rd_seen === 1'b1 && exp_q.size() > 0) begin
      rd_item_t it;
      it = exp_q.pop_front();
      chk(it.tag, bus_rdata, it.exp);
    end
  end

  task automatic wr(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(logic [5:0] a, logic [31:0] e, string tag);
    rd_item_t it;
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    it.exp = e; it.tag = tag;
    exp_q.push_back(it);
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic pulse(logic [31:0] v);
    @(negedge clk);
    evt_in = v;
    @(negedge clk);
    evt_in = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0;
    bus_wdata = '0; evt_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 irq", {31'b0, irq_o}, 0);
    chk("R1 dp_rst", {31'b0, dp_rst_o}, 0);
    chk("R1 rdata", bus_rdata, 0);
    chk("R1 act", {act_width_o, act_height_o}, 0);
    rd(6'h00, 0, "R1 ctrl");
    rd(6'h04, 0, "R1 phy");
    rd(6'h08, 0, "R1 cfg");
    rd(6'h10, 0, "R1 mask");
    rd(6'h14, 0, "R1 src");
    rd(6'h2C, 0, "R1 size");

    // R3 direct controls, R4 staged align not yet active
    wr(6'h00, 32'h8010_0101);
    chk("R3 enable", {31'b0, rx_enable_o}, 1);
    chk("R3 swap", {31'b0, pair_swap_o}, 1);
    chk("R3 wclk", {31'b0, ext_wclk_o}, 1);
    chk("R4 align held", {31'b0, act_align32_o}, 0);
    rd(6'h00, 32'h8010_0101, "R2 ctrl readback");

    // PHY: lane enables direct, settle staged
    wr(6'h04, 32'hA800_001F);
    chk("R3 lane_en", {27'b0, lane_en_o}, 32'h1F);
    chk("R4 settle held", {27'b0, act_settle_o}, 0);
    rd(6'h04, 32'hA800_001F, "R2 phy readback");

    // CFG with junk in unused bits
    wr(6'h08, 32'hFFFF_FFAF);
    chk("R4 dtype held", {26'b0, act_dtype_o}, 0);
    rd(6'h08, 32'h0000_00AF, "R2 cfg readback");

    wr(6'h2C, 32'h0780_0438);
    chk("R4 size held", {act_width_o, act_height_o}, 0);
    rd(6'h2C, 32'h0780_0438, "R2 size readback");

    // R5 commit
    wr(6'h00, 32'h8011_0101);
    chk("R5 align", {31'b0, act_align32_o}, 1);
    chk("R5 dtype", {26'b0, act_dtype_o}, 32'h2B);
    chk("R5 lanes", {30'b0, act_lanes_o}, 3);
    chk("R5 settle", {27'b0, act_settle_o}, 32'h15);
    chk("R5 size", {act_width_o, act_height_o}, 32'h0780_0438);
    rd(6'h00, 32'h8010_0101, "R5 commit reads 0");

    // R4 later staged write leaves active alone
    wr(6'h2C, 32'h0280_01E0);
    wr(6'h00, 32'h8000_0101);
    chk("R4 size unchanged", {act_width_o, act_height_o}, 32'h0780_0438);
    chk("R4 align unchanged", {31'b0, act_align32_o}, 1);
    wr(6'h00, 32'h8001_0101);
    chk("R5 align cleared", {31'b0, act_align32_o}, 0);
    chk("R5 new size", {act_width_o, act_height_o}, 32'h0280_01E0);

    // R12 mask implemented bits
    wr(6'h10, 32'hFFFF_FFFF);
    rd(6'h10, 32'hF000_003F, "R12 mask bits");
    wr(6'h10, 32'h0000_0001);

    // R7 events
    pulse(32'h0000_0103);
    chk("R10 irq lag", {31'b0, irq_o}, 0);
    @(negedge clk);
    chk("R10 irq set", {31'b0, irq_o}, 1);
    rd(6'h14, 32'h0000_0003, "R7 sticky, unimpl bit dropped");

    // R8 W1C
    wr(6'h14, 32'h0000_0001);
    chk("R10 irq old", {31'b0, irq_o}, 1);
    @(negedge clk);
    chk("R10 irq cleared", {31'b0, irq_o}, 0);
    rd(6'h14, 32'h0000_0002, "R8 w1c");
    wr(6'h14, 32'h0000_0000);
    rd(6'h14, 32'h0000_0002, "R8 zero write");

    // R9 event wins over clear
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 6'h14; bus_wdata = 32'h2; evt_in = 32'h2;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; evt_in = '0;
    rd(6'h14, 32'h0000_0002, "R9 event wins");
    wr(6'h14, 32'h0000_0002);
    rd(6'h14, 32'h0000_0000, "R8 cleared");

    // R10 masking
    pulse(32'hF000_0020);
    repeat (2) @(negedge clk);
    chk("R10 masked off", {31'b0, irq_o}, 0);
    wr(6'h10, 32'hF000_0000);
    @(negedge clk);
    chk("R10 mask enables", {31'b0, irq_o}, 1);

    // R11 unmapped
    wr(6'h0C, 32'hFFFF_FFFF);
    wr(6'h18, 32'hFFFF_FFFF);
    rd(6'h0C, 0, "R11 unmapped 0C");
    rd(6'h30, 0, "R11 unmapped 30");
    rd(6'h08, 32'h0000_00AF, "R11 cfg intact");
    rd(6'h04, 32'hA800_001F, "R11 phy intact");

    // R6 software reset
    wr(6'h00, 32'h8000_0111);
    for (int i = 0; i < 16; i++) begin
      chk("R6 pulse high", {31'b0, dp_rst_o}, 1);
      @(negedge clk);
    end
    chk("R6 pulse end", {31'b0, dp_rst_o}, 0);
    rd(6'h14, 0, "R6 src cleared");
    rd(6'h08, 32'h0000_00AF, "R6 cfg kept");
    rd(6'h00, 32'h8000_0101, "R6 reset reads 0");

    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule